// File: doc/BRIEF.md
# Dual-Bank NVRAM Image Validator

This block inspects two redundant, equal-sized configuration images that sit back to back in a byte-wide memory. It decides which image is usable and which one is newer. A single start pulse makes it read every byte of both banks in ascending address order, one byte per cycle. It checks the integrity header of each bank as the bytes stream past, so it needs no local copy of the image.

Each bank begins with a header. The header holds a signature byte, a stored 8-bit header sum, a two-byte length field, a stored 32-bit Adler-style checksum and a 32-bit generation count, followed by the payload. A bank is usable only when three things hold:

- the signature matches the configured constant;
- the folded header sum over the length field matches the stored byte;
- the Adler value over everything from the generation field to the end of the bank matches the stored word.

When both checks are done, the block reports a valid flag and a generation for each bank. It then names the bank to boot from, or raises an error when neither bank can be used. Boot firmware or a configuration loader uses the result to pick the image to copy. The block has no write path.

Top module: `nvram_dual_bank_validator`

## Requirements
- R1: While reset is held and after its release, `done_o`, `rd_en_o`, `sel_bank_o`, `none_valid_o` and both valid flags are 0, and both generation outputs are 0.
- R2: When a start is accepted, `rd_en_o` is high for exactly 2×BANK_BYTES consecutive cycles, and `rd_addr_o` counts 0, 1, …, 2×BANK_BYTES−1. Bank 0 occupies addresses [0, BANK_BYTES) and bank 1 occupies [BANK_BYTES, 2×BANK_BYTES). Read data is taken one cycle after the address.
- R3: `done_o` is high for exactly one cycle, 2×BANK_BYTES+2 cycles after the edge that accepts the start. A start pulse that arrives while a scan is in progress is ignored and neither restarts nor extends the scan.
- R4: A bank whose byte at offset 0 differs from SIG_VALUE (default 0x5A) is invalid.
- R5: The header sum starts at SIG_VALUE and adds the bytes at offsets 2 and 3. It is then folded as (s & 0xFF) + (s >> 8) until it is at most 0xFF. If the result differs from the byte at offset 1, the bank is invalid.
- R6: The Adler value starts with low = 1 and high = 0. For each byte from offset 8 to the end of the bank, low += byte and then high += low. Both halves are taken modulo 65521, and the value is high<<16 | low. If it differs from the big-endian word at offsets 4..7, the bank is invalid.
- R7: A valid bank reports its big-endian generation word from offsets 8..11. An invalid bank reports 0xFFFFFFFF, and its valid flag is 0.
- R8: When at least one bank is valid, `sel_bank_o` is 0 only if bank 0 is valid and either bank 1 is invalid or bank 0's generation is strictly greater as an unsigned number. Otherwise it is 1, so equal generations select bank 1.
- R9: When neither bank is valid, `none_valid_o` is 1 and `sel_bank_o` is 0. Otherwise `none_valid_o` is 0.
- R10: The result outputs change only on the cycle `done_o` is high. They hold their values until the next scan completes, even if the memory contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; accepted when no scan is running |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | $clog2(2×BANK_BYTES) | Byte address of the read request |
| rd_data_i | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | One-cycle pulse when both banks have been judged |
| sel_bank_o | output | 1 | Chosen bank: 0 or 1 |
| none_valid_o | output | 1 | Neither bank holds a valid image |
| bank0_ok_o | output | 1 | Bank 0 passed all checks |
| bank1_ok_o | output | 1 | Bank 1 passed all checks |
| bank0_gen_o | output | 32 | Bank 0 generation, all ones if invalid |
| bank1_gen_o | output | 32 | Bank 1 generation, all ones if invalid |

## Verification
- Read requests are due starting on the cycle after the start is accepted, one per cycle and in order.
- The verdicts arrive 2×BANK_BYTES+2 cycles after that edge, together with the `done_o` pulse.
- The bench drives on falling edges and counts falling edges from the accepting edge. It compares the address on each of those cycles, and it reads every result output exactly on the cycle where `done_o` is due. Any early, late or repeated pulse therefore counts as a miscompare.
- To test R10, the bench checks on the following cycle that the pulse has gone, then rewrites memory and reads the outputs again ten cycles later.

// File: rtl/nvram_chk_pkg.sv
package nvram_chk_pkg;

    localparam int unsigned ADLER_MOD = 65521;

    // Running state of one bank while its bytes stream past.
    typedef struct packed {
        logic [7:0]  sig;
        logic [7:0]  hsum_st;
        logic [15:0] hsum_acc;
        logic [31:0] adler_st;
        logic [31:0] gen;
        logic [15:0] lo;
        logic [15:0] hi;
    } bank_acc_t;

    // End-around fold to a byte; two folds suffice for a 16-bit sum.
    function automatic logic [7:0] fold8(input logic [15:0] s);
        logic [8:0] s1;
        logic [7:0] s2;
        s1 = {1'b0, s[15:8]} + {1'b0, s[7:0]};
        s2 = s1[7:0] + {7'b0, s1[8]};
        return s2;
    endfunction

endpackage

// File: rtl/nvram_rd_seq.sv
module nvram_rd_seq #(
    parameter int BANK_BYTES = 64,
    localparam int AW = $clog2(2 * BANK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          rsp_vld_o,
    output logic [AW-1:0] rsp_idx_o
);
    localparam logic [AW-1:0] LAST_IDX = AW'(2 * BANK_BYTES - 1);

    typedef struct packed {
        logic          act;
        logic [AW-1:0] cnt;
        logic          rsp_vld;
        logic [AW-1:0] rsp_idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rsp_vld = s_q.act;
        s_d.rsp_idx = s_q.cnt;
        if (s_q.act) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST_IDX) begin
                s_d.act = 1'b0;
            end
        end else if (go_i) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_en_o   = s_q.act;
    assign rd_addr_o = s_q.cnt;
    assign rsp_vld_o = s_q.rsp_vld;
    assign rsp_idx_o = s_q.rsp_idx;

endmodule

// File: rtl/nvram_bank_acc.sv
module nvram_bank_acc
    import nvram_chk_pkg::*;
#(
    parameter int         BANK_BYTES = 64,
    parameter logic [7:0] SIG_VALUE  = 8'h5A,
    parameter int         SIG_OFF    = 0,
    parameter int         HSUM_OFF   = 1,
    parameter int         LEN_OFF    = 2,
    parameter int         ADLER_OFF  = 4,
    parameter int         GEN_OFF    = 8,
    localparam int        OW = $clog2(BANK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [OW-1:0] off_i,
    input  logic [7:0]    byte_i,
    output logic          ok_o,
    output logic [31:0]   gen_o
);
    localparam logic [OW-1:0] O_SIG   = OW'(SIG_OFF);
    localparam logic [OW-1:0] O_HSUM  = OW'(HSUM_OFF);
    localparam logic [OW-1:0] O_LEN   = OW'(LEN_OFF);
    localparam logic [OW-1:0] O_ADL   = OW'(ADLER_OFF);
    localparam logic [OW-1:0] O_ADL_E = OW'(ADLER_OFF + 4);
    localparam logic [OW-1:0] O_GEN   = OW'(GEN_OFF);
    localparam logic [OW-1:0] O_GEN_E = OW'(GEN_OFF + 4);
    localparam logic [16:0]   MOD17   = 17'(ADLER_MOD);

    bank_acc_t a_d, a_q;

    always_comb begin
        logic [16:0] lo_s;
        logic [16:0] hi_s;
        a_d  = a_q;
        lo_s = '0;
        hi_s = '0;
        if (vld_i) begin
            if (off_i == '0) begin
                a_d          = '0;
                a_d.hsum_acc = {8'h00, SIG_VALUE};
                a_d.lo       = 16'd1;
            end
            if (off_i == O_SIG) begin
                a_d.sig = byte_i;
            end
            if (off_i == O_HSUM) begin
                a_d.hsum_st = byte_i;
            end
            if (off_i >= O_LEN && off_i < O_ADL) begin
                a_d.hsum_acc = a_d.hsum_acc + {8'h00, byte_i};
            end
            if (off_i >= O_ADL && off_i < O_ADL_E) begin
                a_d.adler_st = {a_d.adler_st[23:0], byte_i};
            end
            if (off_i >= O_GEN && off_i < O_GEN_E) begin
                a_d.gen = {a_d.gen[23:0], byte_i};
            end
            if (off_i >= O_GEN) begin
                lo_s = {1'b0, a_d.lo} + {9'b0, byte_i};
                if (lo_s >= MOD17) begin
                    lo_s = lo_s - MOD17;
                end
                hi_s = {1'b0, a_d.hi} + lo_s;
                if (hi_s >= MOD17) begin
                    hi_s = hi_s - MOD17;
                end
                a_d.lo = lo_s[15:0];
                a_d.hi = hi_s[15:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    always_comb begin
        ok_o = (a_q.sig == SIG_VALUE)
            && (fold8(a_q.hsum_acc) == a_q.hsum_st)
            && ({a_q.hi, a_q.lo} == a_q.adler_st);
        gen_o = ok_o ? a_q.gen : '1;
    end

endmodule

// File: rtl/nvram_bank_pick.sv
module nvram_bank_pick (
    input  logic        ok0_i,
    input  logic [31:0] gen0_i,
    input  logic        ok1_i,
    input  logic [31:0] gen1_i,
    output logic        sel_o,
    output logic        none_o
);
    logic take0;

    always_comb begin
        none_o = !ok0_i && !ok1_i;
        take0  = ok0_i && (!ok1_i || (gen0_i > gen1_i));
        sel_o  = none_o ? 1'b0 : !take0;
    end

endmodule

// File: rtl/nvram_dual_bank_validator.sv
module nvram_dual_bank_validator #(
    parameter int         BANK_BYTES = 64,
    parameter logic [7:0] SIG_VALUE  = 8'h5A,
    parameter int         SIG_OFF    = 0,
    parameter int         HSUM_OFF   = 1,
    parameter int         LEN_OFF    = 2,
    parameter int         ADLER_OFF  = 4,
    parameter int         GEN_OFF    = 8,
    localparam int        AW = $clog2(2 * BANK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          done_o,
    output logic          sel_bank_o,
    output logic          none_valid_o,
    output logic          bank0_ok_o,
    output logic          bank1_ok_o,
    output logic [31:0]   bank0_gen_o,
    output logic [31:0]   bank1_gen_o
);
    localparam int            OW       = $clog2(BANK_BYTES);
    localparam logic [AW-1:0] BANK1_AT = AW'(BANK_BYTES);
    localparam logic [OW-1:0] LAST_OFF = OW'(BANK_BYTES - 1);

    typedef struct packed {
        logic        run;
        logic        eval;
        logic        eval_b1;
        logic        p0_ok;
        logic [31:0] p0_gen;
        logic        b0_ok;
        logic [31:0] b0_gen;
        logic        b1_ok;
        logic [31:0] b1_gen;
        logic        sel;
        logic        none;
        logic        done;
    } top_t;

    top_t t_d, t_q;

    logic          go;
    logic          rsp_vld;
    logic [AW-1:0] rsp_idx;
    logic          rsp_b1;
    logic [OW-1:0] rsp_off;
    logic          acc_ok;
    logic [31:0]   acc_gen;
    logic          pick_sel;
    logic          pick_none;

    assign go = start_i && !t_q.run;

    nvram_rd_seq #(
        .BANK_BYTES(BANK_BYTES)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .rd_en_o  (rd_en_o),
        .rd_addr_o(rd_addr_o),
        .rsp_vld_o(rsp_vld),
        .rsp_idx_o(rsp_idx)
    );

    always_comb begin
        rsp_b1  = (rsp_idx >= BANK1_AT);
        rsp_off = rsp_b1 ? OW'(rsp_idx - BANK1_AT) : OW'(rsp_idx);
    end

    nvram_bank_acc #(
        .BANK_BYTES(BANK_BYTES),
        .SIG_VALUE (SIG_VALUE),
        .SIG_OFF   (SIG_OFF),
        .HSUM_OFF  (HSUM_OFF),
        .LEN_OFF   (LEN_OFF),
        .ADLER_OFF (ADLER_OFF),
        .GEN_OFF   (GEN_OFF)
    ) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (rsp_vld),
        .off_i (rsp_off),
        .byte_i(rd_data_i),
        .ok_o  (acc_ok),
        .gen_o (acc_gen)
    );

    nvram_bank_pick i_pick (
        .ok0_i (t_q.p0_ok),
        .gen0_i(t_q.p0_gen),
        .ok1_i (acc_ok),
        .gen1_i(acc_gen),
        .sel_o (pick_sel),
        .none_o(pick_none)
    );

    always_comb begin
        t_d         = t_q;
        t_d.done    = 1'b0;
        t_d.eval    = rsp_vld && (rsp_off == LAST_OFF);
        t_d.eval_b1 = rsp_b1;
        if (go) begin
            t_d.run = 1'b1;
        end
        if (t_q.eval) begin
            if (!t_q.eval_b1) begin
                t_d.p0_ok  = acc_ok;
                t_d.p0_gen = acc_gen;
            end else begin
                t_d.b0_ok  = t_q.p0_ok;
                t_d.b0_gen = t_q.p0_gen;
                t_d.b1_ok  = acc_ok;
                t_d.b1_gen = acc_gen;
                t_d.sel    = pick_sel;
                t_d.none   = pick_none;
                t_d.done   = 1'b1;
                t_d.run    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign done_o       = t_q.done;
    assign sel_bank_o   = t_q.sel;
    assign none_valid_o = t_q.none;
    assign bank0_ok_o   = t_q.b0_ok;
    assign bank1_ok_o   = t_q.b1_ok;
    assign bank0_gen_o  = t_q.b0_gen;
    assign bank1_gen_o  = t_q.b1_gen;

endmodule

// File: rtl/nvram_dual_bank_check.sv
module nvram_dual_bank_check #(
    parameter int  BANK_BYTES = 64,
    localparam int AW = $clog2(2 * BANK_BYTES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          done_o,
    input logic          sel_bank_o,
    input logic          none_valid_o,
    input logic          bank0_ok_o,
    input logic          bank1_ok_o,
    input logic [31:0]   bank0_gen_o,
    input logic [31:0]   bank1_gen_o
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(2 * BANK_BYTES - 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done_o && !rd_en_o);

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> rd_addr_o <= TOP_ADDR);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o && $past(rd_en_o) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_en_o);

    // R7
    gen0_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !bank0_ok_o |-> bank0_gen_o == 32'hFFFF_FFFF);

    // R7
    gen1_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !bank1_ok_o |-> bank1_gen_o == 32'hFFFF_FFFF);

    // R8
    lone_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (bank0_ok_o != bank1_ok_o) |-> sel_bank_o == bank1_ok_o);

    // R9
    none_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> none_valid_o == (!bank0_ok_o && !bank1_ok_o));

    // R9
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && none_valid_o |-> !sel_bank_o);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(sel_bank_o) && $stable(none_valid_o)
                    && $stable(bank0_ok_o) && $stable(bank1_ok_o)
                    && $stable(bank0_gen_o) && $stable(bank1_gen_o));

endmodule

bind nvram_dual_bank_validator nvram_dual_bank_check #(
    .BANK_BYTES(BANK_BYTES)
) i_nvram_dual_bank_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .done_o      (done_o),
    .sel_bank_o  (sel_bank_o),
    .none_valid_o(none_valid_o),
    .bank0_ok_o  (bank0_ok_o),
    .bank1_ok_o  (bank1_ok_o),
    .bank0_gen_o (bank0_gen_o),
    .bank1_gen_o (bank1_gen_o)
);

// File: tb/test_nvram_dual_bank_validator.sv
module test_nvram_dual_bank_validator;
    localparam int         N   = 64;
    localparam int         AW  = $clog2(2 * N);
    localparam logic [7:0] SIG = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          rd_en_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0]    rd_data_i = '0;
    logic          done_o, sel_bank_o, none_valid_o, bank0_ok_o, bank1_ok_o;
    logic [31:0]   bank0_gen_o, bank1_gen_o;

    logic [7:0] mem [0:2*N-1];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rd_en_o) rd_data_i <= mem[rd_addr_o];
    end

    nvram_dual_bank_validator #(.BANK_BYTES(N), .SIG_VALUE(SIG)) i_nvram_dual_bank_validator (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .done_o(done_o), .sel_bank_o(sel_bank_o), .none_valid_o(none_valid_o),
        .bank0_ok_o(bank0_ok_o), .bank1_ok_o(bank1_ok_o),
        .bank0_gen_o(bank0_gen_o), .bank1_gen_o(bank1_gen_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hsum_ref(input int b);
        int s = SIG;
        for (int i = 2; i < 4; i++) s += mem[b*N+i];
        while (s > 255) s = (s & 255) + (s >> 8);
        return 8'(s);
    endfunction

    function automatic logic [31:0] adler_ref(input int b);
        int unsigned lo = 1, hi = 0;
        for (int i = 8; i < N; i++) begin
            lo += mem[b*N+i];
            hi += lo;
        end
        lo %= 65521;
        hi %= 65521;
        return (hi << 16) | lo;
    endfunction

    function automatic logic [31:0] word_at(input int a);
        return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
    endfunction

    // mode: 0 clean, 1 bad signature, 2 bad header sum, 3 payload hit, 4 bad stored Adler
    task automatic build_bank(input int b, input logic [31:0] gen, input int mode, input bit fold_hi);
        logic [31:0] ad;
        for (int i = 0; i < N; i++) mem[b*N+i] = 8'($urandom);
        mem[b*N] = SIG;
        if (fold_hi) begin
            mem[b*N+2] = 8'hFF;
            mem[b*N+3] = 8'hFF;
        end
        {mem[b*N+8], mem[b*N+9], mem[b*N+10], mem[b*N+11]} = gen;
        ad = adler_ref(b);
        {mem[b*N+4], mem[b*N+5], mem[b*N+6], mem[b*N+7]} = ad;
        mem[b*N+1] = hsum_ref(b);
        case (mode)
            1: mem[b*N]   = mem[b*N] ^ 8'h10;
            2: mem[b*N+1] = mem[b*N+1] ^ 8'h01;
            3: mem[b*N+12+($urandom % (N-12))] ^= 8'h20;
            4: mem[b*N+7] = mem[b*N+7] ^ 8'h04;
            default: ;
        endcase
    endtask

    task automatic ref_bank(input int b, output logic ok, output logic [31:0] gen);
        ok  = (mem[b*N] == SIG) && (hsum_ref(b) == mem[b*N+1]) && (adler_ref(b) == word_at(b*N+4));
        gen = ok ? word_at(b*N+8) : 32'hFFFF_FFFF;
    endtask

    task automatic scan(input string req, input bit poke_mid);
        logic ok0, ok1, e_sel, e_none;
        logic [31:0] g0, g1;
        int addr_bad = 0;
        int seen = 0;
        ref_bank(0, ok0, g0);
        ref_bank(1, ok1, g1);
        e_none = !ok0 && !ok1;
        e_sel  = e_none ? 1'b0 : !(ok0 && (!ok1 || g0 > g1));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j < 2*N; j++) begin
            if (!(rd_en_o === 1'b1 && rd_addr_o === AW'(j))) addr_bad++;
            if (done_o) seen++;
            if (poke_mid && j == 5) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        chk({"R2 addr ", req}, addr_bad, 0);
        chk({"R2 rd_en off ", req}, {31'b0, rd_en_o}, 0);
        @(negedge clk);
        if (done_o) seen++;
        @(negedge clk);
        chk({"R3 early done ", req}, seen, 0);
        chk({"R3 done due ", req}, {31'b0, done_o}, 1);
        chk({"R4 R5 R6 ok0 ", req}, {31'b0, bank0_ok_o}, {31'b0, ok0});
        chk({"R4 R5 R6 ok1 ", req}, {31'b0, bank1_ok_o}, {31'b0, ok1});
        chk({"R7 gen0 ", req}, bank0_gen_o, g0);
        chk({"R7 gen1 ", req}, bank1_gen_o, g1);
        chk({"R8 sel ", req}, {31'b0, sel_bank_o}, {31'b0, e_sel});
        chk({"R9 none ", req}, {31'b0, none_valid_o}, {31'b0, e_none});
        @(negedge clk);
        chk({"R3 pulse width ", req}, {31'b0, done_o}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] h0, h1;
        logic hs;
        void'($urandom(32'd4242));
        for (int i = 0; i < 2*N; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 done", {31'b0, done_o}, 0);
        chk("R1 rd_en", {31'b0, rd_en_o}, 0);
        chk("R1 flags", {28'b0, sel_bank_o, none_valid_o, bank0_ok_o, bank1_ok_o}, 0);
        chk("R1 gens", bank0_gen_o | bank1_gen_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {30'b0, done_o, rd_en_o}, 0);

        build_bank(0, 32'd5, 0, 0); build_bank(1, 32'd3, 0, 0); scan("R8 newer b0", 0);
        build_bank(0, 32'd3, 0, 0); build_bank(1, 32'd5, 0, 0); scan("R8 newer b1", 0);
        build_bank(0, 32'd7, 0, 0); build_bank(1, 32'd7, 0, 0); scan("R8 tie", 0);
        build_bank(0, 32'd9, 1, 0); build_bank(1, 32'd2, 0, 0); scan("R4 sig b0", 0);
        build_bank(0, 32'd1, 0, 0); build_bank(1, 32'd8, 2, 0); scan("R5 hsum b1", 0);
        build_bank(0, 32'd4, 0, 1); build_bank(1, 32'd1, 0, 1); scan("R5 fold", 0);
        build_bank(0, 32'd6, 3, 0); build_bank(1, 32'd2, 0, 0); scan("R6 payload b0", 0);
        build_bank(0, 32'd1, 0, 0); build_bank(1, 32'd6, 4, 0); scan("R6 stored b1", 0);
        build_bank(0, 32'hFFFF_FFFF, 0, 0); build_bank(1, 32'd0, 1, 0); scan("R8 allones valid", 0);
        build_bank(0, 32'd3, 2, 0); build_bank(1, 32'd3, 3, 0); scan("R9 both bad", 0);
        build_bank(0, 32'd2, 0, 0); build_bank(1, 32'd1, 0, 0); scan("R3 mid start", 1);

        // R10: results hold while memory changes and no scan runs
        hs = sel_bank_o; h0 = bank0_gen_o; h1 = bank1_gen_o;
        for (int i = 0; i < 2*N; i++) mem[i] = 8'($urandom);
        repeat (10) @(negedge clk);
        chk("R10 hold gen0", bank0_gen_o, h0);
        chk("R10 hold gen1", bank1_gen_o, h1);
        chk("R10 hold sel", {31'b0, sel_bank_o}, {31'b0, hs});
        chk("R10 no done", {31'b0, done_o}, 0);

        for (int k = 0; k < 40; k++) begin
            build_bank(0, 32'($urandom % 4), int'($urandom % 6) % 5, 1'($urandom));
            build_bank(1, 32'($urandom % 4), int'($urandom % 6) % 5, 1'($urandom));
            scan("R8 random", 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule